// File: doc/BRIEF.md
# NAND Flash Command Front End

This block is the device-side decoder of a parallel NAND flash bus. It runs in the controller's clock domain and samples the chip-enable, command-latch, address-latch, write-strobe, read-strobe and write-protect pins together with the 8-bit I/O bus. Each rising edge of the write strobe is classified as a command, address or data-input cycle. Address bytes are collected into a 12-bit column register and a 17-bit page register. Two-command sequences are tracked, and when a sequence is complete and well formed the block emits a one-cycle operation strobe with a kind code.

The kinds are read, program, erase, column change, status, ID and reset. Read, program and erase start an internal busy timer. While it runs, only status and reset commands are honoured. A low write-protect pin blocks program and erase. The array, the page buffer and the programming physics sit outside this block; the busy timer is a fixed-length stand-in for them.

Top module: `nand_cmd_front`

## Requirements
- R1: A write-strobe rising edge counts only when chip enable is low and the read strobe is high. CLE=1, ALE=0 marks a command byte, CLE=0, ALE=1 marks an address byte, and CLE=0, ALE=0 marks a data byte. CLE=1 with ALE=1 is ignored. A resulting strobe appears in the clock cycle after the edge is sampled.
- R2: After a read or program first command, five address bytes fill the addresses in order. Column bits 7:0 come from byte 1 and bits 11:8 from byte 2, low nibble. Page bits 7:0 come from byte 3, bits 15:8 from byte 4, and bit 16 from bit 0 of byte 5. The upper bits of bytes 2 and 5 are ignored.
- R3: The command pairs 00h/30h, 80h/10h, 60h/D0h and 05h/E0h give op_kind 1 (read), 2 (program), 3 (erase) and 4 (column change). A pair counts only when all its address bytes have arrived. Erase takes three page bytes. Column change takes two column bytes and keeps the page.
- R4: A second command that does not match the pending first command aborts the sequence with no strobe. So does a confirm that arrives before all address bytes, and so does any unknown command. A later matching confirm then also gives nothing.
- R5: Read, program and erase raise busy for exactly BUSY_CYCLES cycles, starting in the strobe cycle. While busy, only 70h/71h (op_kind 5, status) and FFh are accepted. Every other command, address and data cycle is ignored.
- R6: With write-protect low, a program or erase confirm produces no strobe and no busy. Read is unaffected.
- R7: With chip enable high, no strobe has any effect on outputs or addresses.
- R8: FFh gives op_kind 7 (reset) in every state. In that same cycle it clears the pending sequence and both address registers and ends busy.
- R9: After 80h and all five address bytes, each data cycle gives a one-cycle data_valid with the byte. A data cycle is ignored when no program sequence is ready.
- R10: 90h, when not busy, gives op_kind 6 (ID) and drops any pending sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, latched on rising edge |
| re_n | input | 1 | Read strobe, must be high for input cycles |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | I/O bus input byte |
| op_valid | output | 1 | One-cycle operation strobe |
| op_kind | output | 3 | Operation code, valid with op_valid |
| col_addr | output | 12 | Column address register |
| page_addr | output | 17 | Page address register |
| data_valid | output | 1 | One-cycle data input strobe |
| data_byte | output | 8 | Data input byte |
| busy | output | 1 | Busy timer running |

## Verification
The assertions check several rules on every cycle. No array operation strobe follows a busy cycle, and no program or erase strobe follows write-protect low. Deselection suppresses all strobes. The address registers move only after an address-latch cycle or a reset, and a reset strobe always arrives with cleared addresses and no busy. The bench scenarios show the rest: the bit layout of the address bytes, the pairing and abort rules for sequences, the exact busy length, and the gating of data bytes, all of which need a specific sequence of bus cycles.

// File: rtl/nand_fe_pkg.sv
// Shared types and command codes for the NAND command front end.
// Assumes an 8-bit I/O bus and a two-command sequence protocol.
package nand_fe_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_READ   = 3'd1,
        OP_PROG   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_COLCHG = 3'd4,
        OP_STATUS = 3'd5,
        OP_ID     = 3'd6,
        OP_RESET  = 3'd7
    } op_kind_e;

    typedef enum logic [2:0] {
        PD_NONE,
        PD_READ,
        PD_PROG,
        PD_ERASE,
        PD_COLCHG
    } pend_e;

    localparam logic [7:0] C_READ_1  = 8'h00;
    localparam logic [7:0] C_READ_2  = 8'h30;
    localparam logic [7:0] C_PROG_1  = 8'h80;
    localparam logic [7:0] C_PROG_2  = 8'h10;
    localparam logic [7:0] C_ERASE_1 = 8'h60;
    localparam logic [7:0] C_ERASE_2 = 8'hD0;
    localparam logic [7:0] C_COL_1   = 8'h05;
    localparam logic [7:0] C_COL_2   = 8'hE0;
    localparam logic [7:0] C_STAT_A  = 8'h70;
    localparam logic [7:0] C_STAT_B  = 8'h71;
    localparam logic [7:0] C_ID      = 8'h90;
    localparam logic [7:0] C_RESET   = 8'hFF;

endpackage

// File: rtl/nand_bus_sampler.sv
// Detects write-strobe rising edges in the clock domain and classifies
// each as a command, address or data cycle.
// Assumes the bus pins are already synchronous to clk and that each
// strobe level lasts at least one clock.
module nand_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic cle,
    input  logic ale,
    input  logic we_n,
    input  logic re_n,
    output logic cmd_ev,
    output logic addr_ev,
    output logic data_ev
);
    logic we_d;
    logic take;

    // Remember the previous write-strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) we_d <= 1'b1;
        else        we_d <= we_n;
    end

    // A qualified input cycle: strobe rising, selected, not reading.
    always_comb begin
        take    = we_n & ~we_d & ~ce_n & re_n;
        cmd_ev  = take &  cle & ~ale;
        addr_ev = take & ~cle &  ale;
        data_ev = take & ~cle & ~ale;
    end
endmodule

// File: rtl/nand_busy_timer.sv
// Fixed-length busy stand-in for array operations.
// Assumes start and abort never need to coexist; abort wins.
module nand_busy_timer #(
    parameter int BUSY_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Load on start, count down to zero, clear on abort.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (abort)      cnt <= '0;
        else if (start)      cnt <= CNT_W'(BUSY_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/nand_addr_store.sv
// Address byte slots assembled into column and page registers.
// Slot order: column bytes low to high, then page bytes low to high.
// Bits of a byte beyond the register width are dropped.
module nand_addr_store #(
    parameter int COL_W  = 12,
    parameter int PAGE_W = 17,
    localparam int COL_BYTES = (COL_W + 7) / 8,
    localparam int ROW_BYTES = (PAGE_W + 7) / 8,
    localparam int SLOTS     = COL_BYTES + ROW_BYTES,
    localparam int IDX_W     = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        wbyte,
    input  logic              clr,
    output logic [COL_W-1:0]  col_addr,
    output logic [PAGE_W-1:0] page_addr
);
    genvar i;
    generate
        for (i = 0; i < SLOTS; i++) begin : g_slot
            localparam int BASE = (i < COL_BYTES) ? 8 * i : 8 * (i - COL_BYTES);
            localparam int FULL = (i < COL_BYTES) ? COL_W : PAGE_W;
            localparam int W    = (FULL - BASE > 8) ? 8 : FULL - BASE;
            logic [W-1:0] q;

            // Hold one address byte, trimmed to its useful bits.
            always_ff @(posedge clk) begin
                if (!rst_n)                         q <= '0;
                else if (clr)                       q <= '0;
                else if (wr && idx == IDX_W'(i))    q <= wbyte[W-1:0];
            end

            if (i < COL_BYTES) begin : g_col
                assign col_addr[BASE +: W] = q;
            end else begin : g_page
                assign page_addr[BASE +: W] = q;
            end
        end
    endgenerate
endmodule

// File: rtl/nand_seq_ctrl.sv
// Command sequencer: tracks the pending first command, counts address
// bytes, matches confirms, filters by busy and write protect, and
// emits registered operation and data strobes.
// Assumes events arrive at most one per clock.
module nand_seq_ctrl
    import nand_fe_pkg::*;
#(
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3,
    localparam int SLOTS = COL_BYTES + ROW_BYTES,
    localparam int IDX_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_ev,
    input  logic             addr_ev,
    input  logic             data_ev,
    input  logic [7:0]       bus_byte,
    input  logic             busy,
    input  logic             wp_n,
    output logic             op_valid,
    output op_kind_e         op_kind,
    output logic             data_valid,
    output logic [7:0]       data_byte,
    output logic             tmr_start,
    output logic             tmr_abort,
    output logic             a_wr,
    output logic [IDX_W-1:0] a_idx,
    output logic             a_clr
);
    pend_e            pend, pend_n;
    logic [IDX_W-1:0] cnt, cnt_n;
    logic             opv_n, dv_n;
    op_kind_e         kind_n;

    // Address bytes each pending command expects.
    function automatic logic [IDX_W-1:0] need_of(input pend_e p);
        case (p)
            PD_READ, PD_PROG: need_of = IDX_W'(SLOTS);
            PD_ERASE:         need_of = IDX_W'(ROW_BYTES);
            PD_COLCHG:        need_of = IDX_W'(COL_BYTES);
            default:          need_of = '0;
        endcase
    endfunction

    // First slot written by each pending command.
    function automatic logic [IDX_W-1:0] base_of(input pend_e p);
        base_of = (p == PD_ERASE) ? IDX_W'(COL_BYTES) : '0;
    endfunction

    logic ready;
    assign ready = (pend != PD_NONE) && (cnt == need_of(pend));

    // Decide next sequence state and strobes from the current event.
    always_comb begin
        pend_n    = pend;
        cnt_n     = cnt;
        opv_n     = 1'b0;
        kind_n    = OP_NONE;
        dv_n      = 1'b0;
        tmr_start = 1'b0;
        tmr_abort = 1'b0;
        a_wr      = 1'b0;
        a_idx     = base_of(pend) + cnt;
        a_clr     = 1'b0;
        if (cmd_ev) begin
            if (bus_byte == C_RESET) begin
                opv_n = 1'b1; kind_n = OP_RESET;
                pend_n = PD_NONE; cnt_n = '0;
                a_clr = 1'b1; tmr_abort = 1'b1;
            end else if (bus_byte == C_STAT_A || bus_byte == C_STAT_B) begin
                opv_n = 1'b1; kind_n = OP_STATUS;
            end else if (!busy) begin
                cnt_n  = '0;
                pend_n = PD_NONE;
                case (bus_byte)
                    C_READ_1:  pend_n = PD_READ;
                    C_PROG_1:  pend_n = PD_PROG;
                    C_ERASE_1: pend_n = PD_ERASE;
                    C_COL_1:   pend_n = PD_COLCHG;
                    C_ID: begin
                        opv_n = 1'b1; kind_n = OP_ID;
                    end
                    C_READ_2: if (ready && pend == PD_READ) begin
                        opv_n = 1'b1; kind_n = OP_READ; tmr_start = 1'b1;
                    end
                    C_PROG_2: if (ready && pend == PD_PROG && wp_n) begin
                        opv_n = 1'b1; kind_n = OP_PROG; tmr_start = 1'b1;
                    end
                    C_ERASE_2: if (ready && pend == PD_ERASE && wp_n) begin
                        opv_n = 1'b1; kind_n = OP_ERASE; tmr_start = 1'b1;
                    end
                    C_COL_2: if (ready && pend == PD_COLCHG) begin
                        opv_n = 1'b1; kind_n = OP_COLCHG;
                    end
                    default: ;
                endcase
            end
        end else if (addr_ev && !busy && pend != PD_NONE && cnt < need_of(pend)) begin
            a_wr  = 1'b1;
            cnt_n = cnt + 1'b1;
        end else if (data_ev && !busy && pend == PD_PROG && ready) begin
            dv_n = 1'b1;
        end
    end

    // Register sequence state and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= PD_NONE;
            cnt        <= '0;
            op_valid   <= 1'b0;
            op_kind    <= OP_NONE;
            data_valid <= 1'b0;
            data_byte  <= '0;
        end else begin
            pend       <= pend_n;
            cnt        <= cnt_n;
            op_valid   <= opv_n;
            op_kind    <= kind_n;
            data_valid <= dv_n;
            if (dv_n) data_byte <= bus_byte;
        end
    end
endmodule

// File: rtl/nand_cmd_front.sv
// Top of the NAND command front end: pin sampling, sequencing,
// address assembly and the busy stand-in.
// Assumes all pins are synchronous to clk.
module nand_cmd_front
    import nand_fe_pkg::*;
#(
    parameter int BUSY_CYCLES = 20,
    parameter int COL_W       = 12,
    parameter int PAGE_W      = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              we_n,
    input  logic              re_n,
    input  logic              wp_n,
    input  logic [7:0]        io_in,
    output logic              op_valid,
    output logic [2:0]        op_kind,
    output logic [COL_W-1:0]  col_addr,
    output logic [PAGE_W-1:0] page_addr,
    output logic              data_valid,
    output logic [7:0]        data_byte,
    output logic              busy
);
    localparam int COL_BYTES = (COL_W + 7) / 8;
    localparam int ROW_BYTES = (PAGE_W + 7) / 8;
    localparam int IDX_W     = $clog2(COL_BYTES + ROW_BYTES + 1);

    logic             cmd_ev, addr_ev, data_ev;
    logic             tmr_start, tmr_abort;
    logic             a_wr, a_clr;
    logic [IDX_W-1:0] a_idx;
    op_kind_e         kind;

    nand_bus_sampler u_samp (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n),
        .cmd_ev(cmd_ev), .addr_ev(addr_ev), .data_ev(data_ev)
    );

    nand_seq_ctrl #(.COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_ev(cmd_ev), .addr_ev(addr_ev),
        .data_ev(data_ev), .bus_byte(io_in), .busy(busy), .wp_n(wp_n),
        .op_valid(op_valid), .op_kind(kind), .data_valid(data_valid),
        .data_byte(data_byte), .tmr_start(tmr_start), .tmr_abort(tmr_abort),
        .a_wr(a_wr), .a_idx(a_idx), .a_clr(a_clr)
    );

    nand_addr_store #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .wr(a_wr), .idx(a_idx), .wbyte(io_in),
        .clr(a_clr), .col_addr(col_addr), .page_addr(page_addr)
    );

    nand_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .abort(tmr_abort),
        .busy(busy)
    );

    assign op_kind = kind;
endmodule

// File: rtl/nand_cmd_front_chk.sv
// Protocol checker for nand_cmd_front, attached by bind.
module nand_cmd_front_chk #(
    parameter int COL_W  = 12,
    parameter int PAGE_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              ale,
    input logic              wp_n,
    input logic              op_valid,
    input logic [2:0]        op_kind,
    input logic [COL_W-1:0]  col_addr,
    input logic [PAGE_W-1:0] page_addr,
    input logic              data_valid,
    input logic              busy
);
    // R5: a busy cycle is never followed by an array or ID strobe.
    a_r5_busy_filter: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(op_valid && op_kind inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd6}));

    // R5: a busy cycle is never followed by data input.
    a_r5_no_data_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !data_valid);

    // R6: program and erase strobes only follow write-protect high.
    a_r6_wp_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        wp_n == 1'b0 |=> !(op_valid && op_kind inside {3'd2, 3'd3}));

    // R7: deselected cycles produce no strobes.
    a_r7_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !op_valid && !data_valid);

    // R2: address registers change only after an address cycle or reset.
    a_r2_addr_source: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(col_addr) || !$stable(page_addr)) |->
            ($past(ale) || (op_valid && op_kind == 3'd7)));

    // R8: reset strobe comes with cleared addresses and idle timer.
    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd7) |-> (col_addr == '0 && page_addr == '0 && !busy));
endmodule

bind nand_cmd_front nand_cmd_front_chk #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ale(ale), .wp_n(wp_n),
    .op_valid(op_valid), .op_kind(op_kind), .col_addr(col_addr),
    .page_addr(page_addr), .data_valid(data_valid), .busy(busy)
);

// File: tb/tb_nand_cmd_front.sv
// Directed bench for nand_cmd_front: one task per scenario.
module tb_nand_cmd_front;
    localparam int BUSY = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0]  io_in = 8'h00;
    logic        op_valid, data_valid, busy;
    logic [2:0]  op_kind;
    logic [11:0] col_addr;
    logic [16:0] page_addr;
    logic [7:0]  data_byte;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic       s_op, s_dv, s_busy;
    logic [2:0] s_kind;
    logic [7:0] s_db;

    always #4 clk = ~clk;

    nand_cmd_front #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
        .op_valid(op_valid), .op_kind(op_kind), .col_addr(col_addr),
        .page_addr(page_addr), .data_valid(data_valid), .data_byte(data_byte),
        .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write-strobe cycle; outputs captured one clock after the edge.
    task automatic pulse(input logic c, input logic a, input logic sel_n, input logic [7:0] b);
        @(negedge clk);
        ce_n = sel_n; cle = c; ale = a; io_in = b; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        s_op = op_valid; s_kind = op_kind; s_dv = data_valid; s_db = data_byte; s_busy = busy;
        cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);  pulse(1'b1, 1'b0, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b);  pulse(1'b0, 1'b1, 1'b0, b); endtask
    task automatic dat(input logic [7:0] b);  pulse(1'b0, 1'b0, 1'b0, b); endtask

    task automatic addr5(input logic [7:0] b0, b1, b2, b3, b4);
        adr(b0); adr(b1); adr(b2); adr(b3); adr(b4);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 60 && busy; k++) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk(!op_valid && !data_valid && !busy, "R8 reset outputs idle", {op_valid, data_valid, busy}, 0);
        chk(col_addr == 0 && page_addr == 0, "R2 reset addresses", {col_addr, page_addr}, 0);
    endtask

    task automatic t_read();
        cmd(8'h00);
        chk(!s_op, "R3 first command alone", s_op, 0);
        addr5(8'h34, 8'hF7, 8'h56, 8'h9A, 8'hFF);
        chk(col_addr == 12'h734, "R2 column assembly", col_addr, 12'h734);
        chk(page_addr == 17'h19A56, "R2 page assembly", page_addr, 17'h19A56);
        cmd(8'h30);
        chk(s_op && s_kind == 3'd1, "R3 R1 read strobe", {s_op, s_kind}, {1'b1, 3'd1});
        chk(s_busy, "R5 busy with read", s_busy, 1);
        cmd(8'h90);
        chk(!s_op, "R5 ID ignored while busy", {s_op, s_kind}, 0);
        cmd(8'h00); adr(8'h11);
        chk(col_addr == 12'h734, "R5 address ignored while busy", col_addr, 12'h734);
        cmd(8'h70);
        chk(s_op && s_kind == 3'd5, "R5 status while busy", {s_op, s_kind}, {1'b1, 3'd5});
        wait_idle();
    endtask

    task automatic t_colchg();
        cmd(8'h05); adr(8'hAB); adr(8'hF1); cmd(8'hE0);
        chk(s_op && s_kind == 3'd4, "R3 column change strobe", {s_op, s_kind}, {1'b1, 3'd4});
        chk(col_addr == 12'h1AB && page_addr == 17'h19A56, "R3 column change keeps page", {col_addr, page_addr}, {12'h1AB, 17'h19A56});
        chk(!s_busy, "R3 column change no busy", s_busy, 0);
    endtask

    task automatic t_program();
        dat(8'h77);
        chk(!s_dv, "R9 data ignored when not ready", s_dv, 0);
        cmd(8'h80); addr5(8'h00, 8'h00, 8'h01, 8'h00, 8'h00);
        dat(8'h5A);
        chk(s_dv && s_db == 8'h5A, "R9 data strobe", {s_dv, s_db}, {1'b1, 8'h5A});
        dat(8'hC3);
        chk(s_dv && s_db == 8'hC3, "R9 second data strobe", {s_dv, s_db}, {1'b1, 8'hC3});
        cmd(8'h10);
        chk(s_op && s_kind == 3'd2, "R3 program strobe", {s_op, s_kind}, {1'b1, 3'd2});
        chk(page_addr == 17'h00001, "R2 program page", page_addr, 17'h00001);
        wait_idle();
    endtask

    task automatic t_erase_len();
        int n;
        cmd(8'h60); adr(8'h11); adr(8'h22); adr(8'hFE); cmd(8'hD0);
        chk(s_op && s_kind == 3'd3, "R3 erase strobe", {s_op, s_kind}, {1'b1, 3'd3});
        chk(page_addr == 17'h02211, "R3 erase row bytes", page_addr, 17'h02211);
        n = 1;
        while (n < 60) begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
        chk(n == BUSY, "R5 busy length", n, BUSY);
    endtask

    task automatic t_abort();
        cmd(8'h00); addr5(8'h01, 8'h00, 8'h02, 8'h00, 8'h00); cmd(8'h10);
        chk(!s_op && !s_busy, "R4 mismatched confirm", {s_op, s_busy}, 0);
        cmd(8'h30);
        chk(!s_op, "R4 confirm after abort", s_op, 0);
        cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'hD0);
        chk(!s_op && !s_busy, "R4 short address", {s_op, s_busy}, 0);
        cmd(8'h00); addr5(8'h01, 8'h00, 8'h02, 8'h00, 8'h00); cmd(8'h42); cmd(8'h30);
        chk(!s_op, "R4 unknown command aborts", s_op, 0);
        cmd(8'h80); cmd(8'h90);
        chk(s_op && s_kind == 3'd6, "R10 ID strobe", {s_op, s_kind}, {1'b1, 3'd6});
        addr5(8'h01, 8'h00, 8'h02, 8'h00, 8'h00); cmd(8'h10);
        chk(!s_op, "R10 ID drops pending", s_op, 0);
    endtask

    task automatic t_wp();
        wp_n = 1'b0;
        cmd(8'h80); addr5(8'h00, 8'h00, 8'h03, 8'h00, 8'h00); cmd(8'h10);
        chk(!s_op && !s_busy, "R6 program inhibited", {s_op, s_busy}, 0);
        cmd(8'h60); adr(8'h03); adr(8'h00); adr(8'h00); cmd(8'hD0);
        chk(!s_op && !s_busy, "R6 erase inhibited", {s_op, s_busy}, 0);
        cmd(8'h00); addr5(8'h00, 8'h00, 8'h03, 8'h00, 8'h00); cmd(8'h30);
        chk(s_op && s_kind == 3'd1, "R6 read under protect", {s_op, s_kind}, {1'b1, 3'd1});
        wp_n = 1'b1;
        wait_idle();
    endtask

    task automatic t_select();
        logic [11:0] c0;
        c0 = col_addr;
        pulse(1'b1, 1'b0, 1'b1, 8'hFF);
        chk(!s_op, "R7 deselected command", s_op, 0);
        cmd(8'h05); pulse(1'b0, 1'b1, 1'b1, 8'h55);
        chk(col_addr == c0, "R7 deselected address", col_addr, c0);
        pulse(1'b1, 1'b1, 1'b0, 8'h70);
        chk(!s_op, "R1 CLE and ALE both high", s_op, 0);
        re_n = 1'b0; cmd(8'h70); re_n = 1'b1;
        chk(!s_op, "R1 read strobe low blocks", s_op, 0);
    endtask

    task automatic t_ff();
        cmd(8'h00); addr5(8'h12, 8'h03, 8'h45, 8'h01, 8'h01); cmd(8'h30);
        chk(s_busy, "R5 busy before reset", s_busy, 1);
        cmd(8'hFF);
        chk(s_op && s_kind == 3'd7, "R8 reset strobe", {s_op, s_kind}, {1'b1, 3'd7});
        chk(!s_busy && col_addr == 0 && page_addr == 0, "R8 reset clears", {s_busy, col_addr, page_addr}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ce_n = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_read();
        t_colchg();
        t_program();
        t_erase_len();
        t_abort();
        t_wp();
        t_select();
        t_ff();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule